// File: doc/BRIEF.md
# Stripe-Scan Address Generator for a Row-First 2-D Wavelet Engine

This block produces the read schedule for a two-dimensional wavelet transform engine that processes an image in vertical stripes. `S` parallel lifting units sit downstream. The image is square, `N` by `N` pixels. The generator works in a padded column space that has `N+1` columns. Padded column 0 is an all-zero column placed to the left of the image, so padded column `c >= 1` is image column `c-1`. Each stripe is `2S+1` padded columns wide, and two neighbouring stripes share exactly one column. Stripe `r` therefore covers padded columns `2S*r` to `2S*r + 2S`, and there are `N/(2S)` stripes. The boundary columns at multiples of `2S` are fetched twice, once by each stripe that touches them.

A one-cycle `start` pulse begins a scan. On each beat the block presents a whole row segment: all `2S+1` column addresses, the row index, the stripe index and a flag that marks lane 0 as the zero pad. Rows are walked from top to bottom inside a stripe, and then the scan moves right to the next stripe. This row-segment order lets the horizontal transform run before the vertical transform. A beat completes only when `ready` is high. `done` pulses once after the last beat has been accepted.

Top module: `stripe_scan_agen`

## Requirements
- R1: After reset, `valid` and `done` are both 0.
- R2: A `start` sampled high while the block is idle makes `valid` rise at the next clock edge, with `row` = 0 and `stripe` = 0.
- R3: Lane `k` of `cols` (bits `k*CW +: CW`, where `CW = $clog2(N+1)`) carries padded column `stripe*2S + k` for `k = 0..2S`. Lane 0 of stripe `r+1` therefore equals lane `2S` of stripe `r`.
- R4: `pad` is 1 on exactly the beats of stripe 0, which means lane 0 addresses the zero column. On every other stripe `pad` is 0.
- R5: Inside a stripe, rows are issued in the order 0, 1, …, N-1. After row N-1 the next beat is row 0 of the next stripe.
- R6: One scan issues exactly `N * N/(2S)` accepted beats, covering stripes 0 to `N/(2S)-1`.
- R7: `last` is 1 only on the beat with row N-1 of the final stripe.
- R8: While `valid` is 1 and `ready` is 0, `row`, `stripe`, `cols`, `pad` and `last` hold their values and `valid` stays 1.
- R9: `done` is 1 for exactly the one cycle that follows acceptance of the `last` beat. `valid` is 0 in that cycle.
- R10: `start` is ignored while a scan is in progress. The scan position is unaffected.
- R11: A `start` sampled in the cycle in which `done` is high begins a new scan from row 0, stripe 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Pulse that begins a scan when idle |
| ready | input | 1 | Downstream accepts the current beat |
| valid | output | 1 | A row segment is being presented |
| last | output | 1 | Current beat is the final one of the scan |
| done | output | 1 | One-cycle pulse after the final beat is accepted |
| row | output | $clog2(N) | Row index of the current beat |
| stripe | output | max(1,$clog2(N/(2S))) | Stripe index of the current beat |
| pad | output | 1 | Lane 0 addresses the zero pad column |
| cols | output | (2S+1)*$clog2(N+1) | Padded column addresses, lane k in bits k*CW +: CW |

## Verification
The scoreboard compares every accepted beat against a model of the stripe walk. A design that shifted stripe bases by `2S+1` instead of `2S` would drop the shared boundary column, and lane 0 of a later stripe would no longer match lane `2S` of the stripe before it. The bench applies random and bursty backpressure, which catches a generator that advances on `valid` alone and skips rows, or whose outputs drift while stalled. It also pulses `start` in the middle of a scan and in the `done` cycle. These pulses expose a design that restarts in the middle of a scan, or one that ignores a start arriving on the same cycle as completion. A `pad` flag that stays high beyond stripe 0, or a `done` that lasts two cycles or comes before the last acceptance, fails the per-beat and completion checks.

// File: rtl/stripe_scan_pkg.sv
package stripe_scan_pkg;

    typedef enum logic [0:0] {
        SCAN_IDLE = 1'b0,
        SCAN_RUN  = 1'b1
    } scan_state_e;

endpackage

// File: rtl/sscan_walker.sv
// Row/stripe position counter: top-down inside a stripe, then next stripe.
module sscan_walker
    import stripe_scan_pkg::*;
#(
    parameter int N  = 16,
    parameter int S  = 2,
    parameter int RW = (N > 1) ? $clog2(N) : 1,
    parameter int SW = ((N / (2 * S)) > 1) ? $clog2(N / (2 * S)) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          ready,
    output logic          busy,
    output logic          last,
    output logic          done,
    output logic [RW-1:0] row,
    output logic [SW-1:0] stripe
);

    localparam int NUM_STRIPES = N / (2 * S);
    localparam logic [RW-1:0] ROW_MAX    = RW'(N - 1);
    localparam logic [SW-1:0] STRIPE_MAX = SW'(NUM_STRIPES - 1);

    typedef struct packed {
        scan_state_e   state;
        logic [RW-1:0] row;
        logic [SW-1:0] stripe;
        logic          done;
    } walk_t;

    walk_t st_d, st_q;
    logic  at_end;

    assign at_end = (st_q.state == SCAN_RUN) &&
                    (st_q.row == ROW_MAX) && (st_q.stripe == STRIPE_MAX);

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        unique case (st_q.state)
            SCAN_IDLE: begin
                if (start) begin
                    st_d.state  = SCAN_RUN;
                    st_d.row    = '0;
                    st_d.stripe = '0;
                end
            end
            SCAN_RUN: begin
                if (ready) begin
                    if (at_end) begin
                        st_d.state = SCAN_IDLE;
                        st_d.done  = 1'b1;
                    end else if (st_q.row == ROW_MAX) begin
                        st_d.row    = '0;
                        st_d.stripe = st_q.stripe + SW'(1);
                    end else begin
                        st_d.row = st_q.row + RW'(1);
                    end
                end
            end
            default: st_d.state = SCAN_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{state: SCAN_IDLE, row: '0, stripe: '0, done: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy   = (st_q.state == SCAN_RUN);
    assign last   = at_end;
    assign done   = st_q.done;
    assign row    = st_q.row;
    assign stripe = st_q.stripe;

endmodule

// File: rtl/sscan_lanes.sv
// Expands a stripe index into its 2S+1 padded column addresses.
module sscan_lanes #(
    parameter int N  = 16,
    parameter int S  = 2,
    parameter int SW = 2,
    parameter int CW = $clog2(N + 1)
) (
    input  logic [SW-1:0]           stripe,
    output logic [(2*S+1)*CW-1:0]   cols,
    output logic                    pad
);

    localparam int LANES = 2 * S + 1;

    logic [CW-1:0] base;

    assign base = CW'(stripe) * CW'(2 * S);
    assign pad  = (stripe == '0);

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign cols[k*CW +: CW] = base + CW'(k);
    end

endmodule

// File: rtl/stripe_scan_agen.sv
module stripe_scan_agen #(
    parameter int N = 16,
    parameter int S = 2,
    localparam int RW = (N > 1) ? $clog2(N) : 1,
    localparam int SW = ((N / (2 * S)) > 1) ? $clog2(N / (2 * S)) : 1,
    localparam int CW = $clog2(N + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic                   ready,
    output logic                   valid,
    output logic                   last,
    output logic                   done,
    output logic [RW-1:0]          row,
    output logic [SW-1:0]          stripe,
    output logic                   pad,
    output logic [(2*S+1)*CW-1:0]  cols
);

    sscan_walker #(.N(N), .S(S), .RW(RW), .SW(SW)) u_walk (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .ready  (ready),
        .busy   (valid),
        .last   (last),
        .done   (done),
        .row    (row),
        .stripe (stripe)
    );

    sscan_lanes #(.N(N), .S(S), .SW(SW), .CW(CW)) u_lanes (
        .stripe (stripe),
        .cols   (cols),
        .pad    (pad)
    );

endmodule

// File: rtl/stripe_scan_agen_chk.sv
module stripe_scan_agen_chk #(
    parameter int N  = 16,
    parameter int S  = 2,
    parameter int RW = 4,
    parameter int SW = 2,
    parameter int CW = 5
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  ready,
    input logic                  valid,
    input logic                  last,
    input logic                  done,
    input logic [RW-1:0]         row,
    input logic [SW-1:0]         stripe,
    input logic                  pad,
    input logic [(2*S+1)*CW-1:0] cols
);

    localparam logic [RW-1:0] ROW_MAX    = RW'(N - 1);
    localparam logic [SW-1:0] STRIPE_MAX = SW'(N / (2 * S) - 1);
    localparam int TOP = 2 * S;

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        valid && !ready |=> valid && $stable(row) && $stable(stripe) && $stable(cols)); // R8

    AST_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        valid && ready && !last && (row != ROW_MAX) |=>
            valid && (row == RW'($past(row) + RW'(1))) && $stable(stripe)); // R5

    AST_STRIPE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        valid && ready && !last && (row == ROW_MAX) |=>
            valid && (row == '0) && (stripe == SW'($past(stripe) + SW'(1)))); // R5

    AST_SHARED_COLUMN: assert property (@(posedge clk) disable iff (!rst_n)
        valid && ready && !last && (row == ROW_MAX) |=>
            cols[0 +: CW] == $past(cols[TOP*CW +: CW])); // R3

    AST_PAD_ONLY_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        valid && (stripe != '0) |-> !pad); // R4

    AST_LAST_POSITION: assert property (@(posedge clk) disable iff (!rst_n)
        last |-> valid && (row == ROW_MAX) && (stripe == STRIPE_MAX)); // R7

    AST_DONE_FOLLOWS_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        valid && ready && last |=> done && !valid); // R9

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9

endmodule

bind stripe_scan_agen stripe_scan_agen_chk #(
    .N(N), .S(S), .RW(RW), .SW(SW), .CW(CW)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .ready  (ready),
    .valid  (valid),
    .last   (last),
    .done   (done),
    .row    (row),
    .stripe (stripe),
    .pad    (pad),
    .cols   (cols)
);

// File: tb/stripe_scan_agen_test.sv
`timescale 1ns/1ps
module stripe_scan_agen_test;

    localparam int N  = 16;
    localparam int S  = 2;
    localparam int NS = N / (2 * S);
    localparam int RW = $clog2(N);
    localparam int SW = (NS > 1) ? $clog2(NS) : 1;
    localparam int CW = $clog2(N + 1);
    localparam int LANES = 2 * S + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic ready = 1'b1;
    logic valid, last, done, pad;
    logic [RW-1:0] row;
    logic [SW-1:0] stripe;
    logic [LANES*CW-1:0] cols;

    int vectors = 0;
    int fails = 0;
    bit finished = 1'b0;
    int ready_mode = 0;
    logic [15:0] lfsr = 16'hACE1;

    int exp_row[$];
    int exp_str[$];

    always #2.5 clk = ~clk;

    stripe_scan_agen #(.N(N), .S(S)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .ready(ready),
        .valid(valid), .last(last), .done(done), .row(row),
        .stripe(stripe), .pad(pad), .cols(cols)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    endtask

    // backpressure pattern, changed just after each rising edge
    always begin
        @(posedge clk);
        #1;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        case (ready_mode)
            0: ready = 1'b1;
            1: ready = lfsr[0];
            default: ready = (lfsr[2:0] != 3'b000) && (lfsr[5:3] != 3'b111);
        endcase
    end

    // driver side: queue the complete expected walk
    task automatic push_scan();
        for (int s = 0; s < NS; s++)
            for (int r = 0; r < N; r++) begin
                exp_row.push_back(r);
                exp_str.push_back(s);
            end
    endtask

    // monitor / scoreboard
    bit stalled_prev = 1'b0;
    bit acc_last_prev = 1'b0;
    logic [RW-1:0] h_row;
    logic [SW-1:0] h_str;
    logic [LANES*CW-1:0] h_cols;
    logic h_pad, h_last;

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (stalled_prev) begin
                chk(valid && row == h_row && stripe == h_str && cols == h_cols &&
                    pad == h_pad && last == h_last, "R8 stall hold",
                    int'(row), int'(h_row));
            end
            stalled_prev = valid && !ready;
            h_row = row; h_str = stripe; h_cols = cols; h_pad = pad; h_last = last;

            if (done || acc_last_prev) begin
                chk(done == acc_last_prev, "R9 done timing", int'(done), int'(acc_last_prev));
                chk(!valid, "R9 valid low on done", int'(valid), 0);
                chk(exp_row.size() == 0, "R6 beat count", exp_row.size(), 0);
            end
            acc_last_prev = 1'b0;

            if (valid && ready) begin
                if (exp_row.size() == 0) begin
                    chk(1'b0, "R6 extra beat", int'(row), -1);
                end else begin
                    int er, es;
                    er = exp_row.pop_front();
                    es = exp_str.pop_front();
                    chk(int'(row) == er, "R5 row order", int'(row), er);
                    chk(int'(stripe) == es, "R5 stripe order", int'(stripe), es);
                    for (int k = 0; k < LANES; k++)
                        chk(int'(cols[k*CW +: CW]) == es * 2 * S + k, "R3 lane column",
                            int'(cols[k*CW +: CW]), es * 2 * S + k);
                    chk(pad == (es == 0), "R4 pad flag", int'(pad), int'(es == 0));
                    chk(last == (er == N - 1 && es == NS - 1), "R7 last flag",
                        int'(last), int'(er == N - 1 && es == NS - 1));
                    acc_last_prev = last;
                end
            end
        end
    end

    task automatic wait_done();
        do @(negedge clk); while (!done);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!valid, "R1 reset valid", int'(valid), 0);
        chk(!done, "R1 reset done", int'(done), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!valid, "R1 idle after reset", int'(valid), 0);

        // scan A: free-flowing, stray start mid-scan (R10)
        ready_mode = 0;
        push_scan();
        @(posedge clk); #1 start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
        @(negedge clk);
        chk(valid && row == 0 && stripe == 0, "R2 start response", int'(valid), 1);
        repeat (20) @(posedge clk);
        #1 start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
        @(negedge clk);
        chk(valid, "R10 scan continues", int'(valid), 1);
        wait_done();

        // idle: no start, nothing issued
        repeat (4) @(negedge clk);
        chk(!valid && !done, "R2 idle stays quiet", int'(valid), 0);

        // scan B: random stalls with start pulses during the scan (R8, R10)
        ready_mode = 1;
        push_scan();
        @(posedge clk); #1 start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
        for (int i = 0; i < 6; i++) begin
            repeat (15) @(posedge clk);
            #1 start = 1'b1;
            @(posedge clk); #1 start = 1'b0;
        end
        wait_done();

        // scan C: started during the done cycle (R11), bursty stalls
        #1;
        ready_mode = 2;
        push_scan();
        start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
        @(negedge clk);
        chk(valid && row == 0 && stripe == 0, "R11 restart in done cycle",
            int'(valid), 1);
        wait_done();

        repeat (3) @(negedge clk);
        chk(!valid && !done, "R9 single done pulse", int'(done), 0);
        summary();
    end

endmodule